// File: doc/BRIEF.md
# SRAM Data-Retention Power Sequencer

This block supervises an external low-power static RAM as it enters and leaves a low-voltage data-retention mode. It sits between the memory controller and the power-control logic. The controller asks for sleep and wake through request pulses and reports when it has no access in flight. The power-control logic reports through a supply-good flag whether the rail is at full operating voltage. The block drives a chip-enable override that holds the memory deselected, a permission that lets the power-control logic lower the rail, an access-allowed flag for the controller, and a 2-bit status code.

There are four states: ACTIVE (code 0), DISABLE (code 1), RETAIN (code 2) and RECOVER (code 3). The transitions are as follows. ACTIVE to DISABLE happens on a sleep request while the controller is idle. DISABLE to RETAIN happens once the chip-disable lead interval ends. RETAIN to RECOVER happens once a wake request has been seen and the supply is good. RECOVER to ACTIVE happens once the recovery interval has run on an uninterrupted good supply. The recovery interval is a cycle count derived from the clock frequency and a millisecond figure. A drop of supply-good during RECOVER restarts that count.

Top module: `sram_retention_seq`

## Requirements
- R1: After reset the status is 0 (ACTIVE), access_ok is 1, and both ce_force_off and supply_lower_ok are 0.
- R2: In ACTIVE, a sleep_req while ctrl_idle is 0 is ignored and the state stays ACTIVE.
- R3: In ACTIVE, a sleep_req with ctrl_idle at 1 moves the block to DISABLE (status 1) at the next edge. From that same cycle access_ok is 0 and ce_force_off is 1.
- R4: DISABLE lasts exactly LEAD_CYCLES+1 cycles and then moves to RETAIN. supply_lower_ok is never asserted unless ce_force_off was already 1 in the preceding cycle.
- R5: In RETAIN (status 2), supply_lower_ok and ce_force_off are 1 and access_ok is 0. A sleep_req has no effect in this state.
- R6: A wake_req in RETAIN drops supply_lower_ok at the next edge, and the request is held. The block enters RECOVER (status 3) only at an edge where supply_good is 1, either with the wake or after it.
- R7: In RECOVER, ce_force_off is 1 and access_ok is 0. After (CLK_HZ/1000)*RECOVER_MS+1 cycles with supply_good at 1, the block returns to ACTIVE with access_ok at 1 and ce_force_off at 0.
- R8: A cycle with supply_good at 0 during RECOVER restarts the recovery count from zero, and the state stays RECOVER.
- R9: A wake_req in ACTIVE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Controller request to enter retention |
| wake_req | input | 1 | Controller request to leave retention |
| ctrl_idle | input | 1 | Controller has no access in flight |
| supply_good | input | 1 | Memory rail is at full operating voltage |
| ce_force_off | output | 1 | Hold the memory chip enable inactive |
| supply_lower_ok | output | 1 | Power control may lower the rail |
| access_ok | output | 1 | Controller may access the memory |
| status | output | 2 | State code: 0 ACTIVE, 1 DISABLE, 2 RETAIN, 3 RECOVER |

## Verification
All outputs decode from the state register in the same cycle, so a wrong state appears at the status port at the first sample after the faulty edge. The scoreboard compares every cycle. An off-by-one in either interval counter shows up as a status change one cycle early or late at the DISABLE-to-RETAIN or RECOVER-to-ACTIVE boundary. A lost wake or a recovery count that fails to restart shows up within one cycle as a wrong supply_lower_ok value, or too early a rise of access_ok.

// File: rtl/sram_ret_pkg.sv
package sram_ret_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_DISABLE = 2'd1,
        ST_RETAIN  = 2'd2,
        ST_RECOVER = 2'd3
    } ret_state_t;
endpackage

// File: rtl/ret_interval_timer.sv
module ret_interval_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int unsigned W = $clog2(LIMIT + 2);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

    generate
        if (LIMIT > 0) begin : g_restart_chk
            // A clear must push the count back below its limit (R8)
            assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> !expired);
        end
    endgenerate
endmodule

// File: rtl/ret_fsm.sv
module ret_fsm
    import sram_ret_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       ctrl_idle,
    input  logic       supply_good,
    input  logic       lead_done,
    input  logic       rec_done,
    output ret_state_t state,
    output logic       ce_force_off,
    output logic       supply_lower_ok,
    output logic       access_ok
);
    ret_state_t state_q, state_d;
    logic       wake_pend;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:  if (sleep_req && ctrl_idle)                 state_d = ST_DISABLE;
            ST_DISABLE: if (lead_done)                              state_d = ST_RETAIN;
            ST_RETAIN:  if ((wake_req || wake_pend) && supply_good) state_d = ST_RECOVER;
            ST_RECOVER: if (rec_done && supply_good)                state_d = ST_ACTIVE;
            default:                                                state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_ACTIVE;
            wake_pend <= 1'b0;
        end else begin
            state_q   <= state_d;
            wake_pend <= (state_q == ST_RETAIN) && (state_d == ST_RETAIN)
                         && (wake_req || wake_pend);
        end
    end

    always_comb begin
        ce_force_off    = 1'b1;
        supply_lower_ok = 1'b0;
        access_ok       = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                ce_force_off = 1'b0;
                access_ok    = 1'b1;
            end
            ST_DISABLE: ;
            ST_RETAIN:  supply_lower_ok = !wake_pend;
            ST_RECOVER: ;
            default:    ;
        endcase
    end

    assign state = state_q;

    assert_busy_sleep_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && sleep_req && !ctrl_idle) |=> state_q == ST_ACTIVE);
    assert_sleep_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && sleep_req && ctrl_idle) |=> (state_q == ST_DISABLE && !access_ok));
    assert_lower_after_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_lower_ok) |-> $past(ce_force_off));
    assert_wake_drops_lower_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETAIN && wake_req) |=> !supply_lower_ok);
    assert_wake_needs_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETAIN && !supply_good) |=> state_q != ST_RECOVER);
    assert_no_access_when_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> !ce_force_off);
    assert_recover_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && !supply_good) |=> state_q == ST_RECOVER);
    assert_active_ignores_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !sleep_req) |=> state_q == ST_ACTIVE);
endmodule

// File: rtl/sram_retention_seq.sv
module sram_retention_seq
    import sram_ret_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned RECOVER_MS  = 5,
    parameter int unsigned LEAD_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       ctrl_idle,
    input  logic       supply_good,
    output logic       ce_force_off,
    output logic       supply_lower_ok,
    output logic       access_ok,
    output logic [1:0] status
);
    localparam int unsigned REC_CYCLES = (CLK_HZ / 1000) * RECOVER_MS;

    ret_state_t state;
    logic       lead_done, rec_done;
    logic       lead_clear, rec_clear;

    assign lead_clear = (state != ST_DISABLE);
    assign rec_clear  = (state != ST_RECOVER) || !supply_good;

    ret_interval_timer #(.LIMIT(LEAD_CYCLES)) i_lead_timer (
        .clk(clk), .rst_n(rst_n), .clear(lead_clear), .expired(lead_done)
    );

    ret_interval_timer #(.LIMIT(REC_CYCLES)) i_rec_timer (
        .clk(clk), .rst_n(rst_n), .clear(rec_clear), .expired(rec_done)
    );

    ret_fsm i_fsm (
        .clk(clk), .rst_n(rst_n),
        .sleep_req(sleep_req), .wake_req(wake_req),
        .ctrl_idle(ctrl_idle), .supply_good(supply_good),
        .lead_done(lead_done), .rec_done(rec_done),
        .state(state), .ce_force_off(ce_force_off),
        .supply_lower_ok(supply_lower_ok), .access_ok(access_ok)
    );

    assign status = state;

    // Leaving DISABLE only after the full lead interval (R4)
    assert_lead_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1 && !lead_done) |=> status == 2'd1);
    // Access may only reopen from RECOVER once the count has finished (R7)
    assert_access_after_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd3 && !rec_done) |=> !access_ok);
endmodule

// File: tb/test_sram_retention_seq.sv
module test_sram_retention_seq;
    localparam int unsigned CLK_HZ = 10_000;
    localparam int unsigned REC_MS = 5;
    localparam int unsigned LEAD   = 2;
    localparam int unsigned REC    = (CLK_HZ / 1000) * REC_MS;

    typedef struct packed {
        logic [1:0] code;
        logic       acc;
        logic       ce;
        logic       low;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b0, supply_good = 1'b1;
    logic ce_force_off, supply_lower_ok, access_ok;
    logic [1:0] status;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    sram_retention_seq #(.CLK_HZ(CLK_HZ), .RECOVER_MS(REC_MS), .LEAD_CYCLES(LEAD)) i_sram_retention_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .ctrl_idle(ctrl_idle), .supply_good(supply_good),
        .ce_force_off(ce_force_off), .supply_lower_ok(supply_lower_ok),
        .access_ok(access_ok), .status(status)
    );

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (status !== e.code || access_ok !== e.acc || ce_force_off !== e.ce
                || supply_lower_ok !== e.low) begin
                errors++;
                $display("FAIL %s: got status=%0d acc=%b ce=%b low=%b, expected status=%0d acc=%b ce=%b low=%b",
                         t, status, access_ok, ce_force_off, supply_lower_ok,
                         e.code, e.acc, e.ce, e.low);
            end
        end
    end

    task automatic cyc(input logic s, input logic w, input logic idl, input logic g,
                       input logic [1:0] code, input logic acc, input logic ce,
                       input logic low, input string tag);
        @(negedge clk);
        #1;
        sleep_req = s; wake_req = w; ctrl_idle = idl; supply_good = g;
        exp_q.push_back('{code: code, acc: acc, ce: ce, low: low});
        tag_q.push_back(tag);
    endtask

    task automatic to_retain(input logic g);
        cyc(1, 0, 1, 1, 2'd1, 0, 1, 0, "R3");
        for (int i = 0; i < LEAD; i++) cyc(1, 0, 1, 1, 2'd1, 0, 1, 0, "R4");
        cyc(0, 0, 1, g, 2'd2, 0, 1, 1, "R4");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state (R1)
        for (int i = 0; i < 2; i++) cyc(0, 0, 1, 1, 2'd0, 1, 0, 0, "R1");
        // sleep while busy is ignored (R2), wake in ACTIVE ignored (R9)
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 2'd0, 1, 0, 0, "R2");
        for (int i = 0; i < 2; i++) cyc(0, 1, 1, 1, 2'd0, 1, 0, 0, "R9");
        // first retention pass, supply lowered
        to_retain(0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 2'd2, 0, 1, 1, "R5");
        // wake while the supply is low: permission withdrawn, wait (R6)
        cyc(0, 1, 1, 0, 2'd2, 0, 1, 0, "R6");
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 2'd2, 0, 1, 0, "R6");
        // supply returns: enter RECOVER
        cyc(0, 0, 1, 1, 2'd3, 0, 1, 0, "R6");
        for (int i = 0; i < 20; i++) cyc(0, 0, 1, 1, 2'd3, 0, 1, 0, "R7");
        // supply glitch restarts the count (R8)
        cyc(0, 0, 1, 0, 2'd3, 0, 1, 0, "R8");
        for (int i = 0; i < REC; i++) cyc(0, 0, 1, 1, 2'd3, 0, 1, 0, "R8");
        cyc(0, 0, 1, 1, 2'd0, 1, 0, 0, "R7");
        cyc(0, 0, 1, 1, 2'd0, 1, 0, 0, "R7");
        // second pass, supply never lowered, wake with good supply
        to_retain(1);
        cyc(0, 1, 1, 1, 2'd3, 0, 1, 0, "R6");
        for (int i = 0; i < REC; i++) cyc(0, 0, 1, 1, 2'd3, 0, 1, 0, "R7");
        cyc(0, 0, 1, 1, 2'd0, 1, 0, 0, "R7");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule